// File: doc/BRIEF.md
# Video Fetch Address Counter with Line Skip

This block holds the byte address from which the display engine reads screen memory. Each display fetch moves the address forward by one 16-bit word. At the end of every visible line a programmable skip, counted in words, is added, so that a line can step over memory. This lets the visible window sit inside a wider virtual screen. At the start of each frame the address is reloaded from a base register.

The line-end addition is not done by the plain incrementer. A ripple chain of one-bit full-adder cells adds the word-aligned skip to the current word address. Each cell's sum is the XOR of its three inputs, and each cell's carry is the majority of its three inputs. The chain's result is captured into the address register on the clock edge where the line-end input is first seen high.

A small state machine runs the block. It has two states. In `VA_HALT`, entered at reset, the address is frozen. A frame-start strobe takes it to `VA_RUN`, where it stays until the next reset. In `VA_RUN` one update is chosen per cycle. A frame start gives a load. Otherwise a line-end rising edge gives a skip. Otherwise a fetch gives a step. Otherwise the address holds.

Top module: `vid_addr_gen`

## Requirements
- R1: After reset `vaddr_o` is 0. Fetch and line-end inputs leave it at 0 until the first frame-start strobe.
- R2: A frame-start strobe loads `base_addr_i` with bit 0 cleared. The new address is visible one cycle later. Frame start wins over fetch and line-end in the same cycle.
- R3: In run, a fetch strobe with no frame start and no line-end rising edge adds 2 to the address one cycle later.
- R4: In run, a line-end rising edge (high now, low in the previous cycle) with no frame start adds 2 × `line_skip_i` to the address. The result is visible in the following cycle.
- R5: The skip carry is a true majority. Address 0x0000A8 with skip 0x0F becomes 0x0000C6, not 0x0000B6.
- R6: A line-end input held high adds the skip only once. During the later high cycles, fetch strobes step the address normally.
- R7: When a fetch coincides with a line-end rising edge, only the skip is applied. That fetch adds nothing.
- R8: The address wraps modulo 2^24. For example, 0xFFFFF0 with skip 0x10 becomes 0x000010.
- R9: Bit 0 of `vaddr_o` is always 0.
- R10: A line-end rising edge with a skip of 0 leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 1 | One display word fetched this cycle |
| line_end_i | input | 1 | Line end; the rising edge triggers the skip |
| frame_start_i | input | 1 | Reload from base this cycle |
| base_addr_i | input | 24 | Frame base byte address |
| line_skip_i | input | 8 | Per-line skip in 16-bit words |
| vaddr_o | output | 24 | Current fetch byte address |

## Verification
The hard case is a carry that ripples through many cells of the skip adder. The address only reaches a given value through long runs of fetches and earlier skips. To reach such values, the stimulus sweeps every skip value from 0 to 255 one line after another, starting from several bases. These include a base just below the top of the address space, so that carries cross byte boundaries and the address wraps. Directed cases cover the held line-end input and the fetch that coincides with a line-end edge.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;
    typedef enum logic [0:0] {
        VA_HALT = 1'b0,
        VA_RUN  = 1'b1
    } va_state_e;

    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_SKIP = 2'd2,
        UPD_STEP = 2'd3
    } va_upd_e;
endpackage

// File: rtl/vaddr_fa_cell.sv
// One-bit full adder: sum is parity, carry is majority of the three inputs.
module vaddr_fa_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = a_i ^ b_i ^ c_i;
    assign c_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/vaddr_skip_adder.sv
// Ripple chain of full-adder cells adding a zero-extended word skip to a
// word address; the carry out of the top bit is dropped (address wraps).
module vaddr_skip_adder #(
    parameter int WORD_W = 23,
    parameter int SKIP_W = 8
) (
    input  logic [WORD_W-1:0] word_i,
    input  logic [SKIP_W-1:0] skip_i,
    output logic [WORD_W-1:0] sum_o
);
    logic [WORD_W-1:0] carry;
    logic [WORD_W-1:0] opnd;

    assign carry[0] = 1'b0;

    for (genvar g = 0; g < WORD_W; g++) begin : g_bit
        if (g < SKIP_W) begin : g_ext
            assign opnd[g] = skip_i[g];
        end else begin : g_zero
            assign opnd[g] = 1'b0;
        end

        if (g < WORD_W - 1) begin : g_cell
            vaddr_fa_cell u_cell (
                .a_i (word_i[g]),
                .b_i (opnd[g]),
                .c_i (carry[g]),
                .s_o (sum_o[g]),
                .c_o (carry[g+1])
            );
        end else begin : g_top
            assign sum_o[g] = word_i[g] ^ opnd[g] ^ carry[g];
        end
    end
endmodule

// File: rtl/vaddr_ctrl.sv
// Run/halt state machine with line-end edge detection and update selection.
module vaddr_ctrl
    import vaddr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fetch_i,
    input  logic    line_end_i,
    input  logic    frame_start_i,
    output va_upd_e upd_o
);
    va_state_e state_q, state_d;
    logic      line_q;
    logic      line_rise;

    assign line_rise = line_end_i & ~line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VA_HALT;
            line_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            line_q  <= line_end_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VA_HALT: if (frame_start_i) state_d = VA_RUN;
            VA_RUN:  state_d = VA_RUN;
            default: state_d = VA_HALT;
        endcase
    end

    always_comb begin
        upd_o = UPD_HOLD;
        unique case (state_q)
            VA_HALT: begin
                if (frame_start_i) upd_o = UPD_LOAD;
            end
            VA_RUN: begin
                if (frame_start_i)  upd_o = UPD_LOAD;
                else if (line_rise) upd_o = UPD_SKIP;
                else if (fetch_i)   upd_o = UPD_STEP;
                else                upd_o = UPD_HOLD;
            end
            default: upd_o = UPD_HOLD;
        endcase
    end
endmodule

// File: rtl/vid_addr_gen.sv
module vid_addr_gen
    import vaddr_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SKIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              line_end_i,
    input  logic              frame_start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [SKIP_W-1:0] line_skip_i,
    output logic [ADDR_W-1:0] vaddr_o
);
    localparam int WORD_W = ADDR_W - 1;

    va_upd_e           upd;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] skip_sum;

    vaddr_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_i       (fetch_i),
        .line_end_i    (line_end_i),
        .frame_start_i (frame_start_i),
        .upd_o         (upd)
    );

    vaddr_skip_adder #(
        .WORD_W (WORD_W),
        .SKIP_W (SKIP_W)
    ) u_skip (
        .word_i (word_q),
        .skip_i (line_skip_i),
        .sum_o  (skip_sum)
    );

    always_comb begin
        unique case (upd)
            UPD_LOAD: word_d = base_addr_i[ADDR_W-1:1];
            UPD_SKIP: word_d = skip_sum;
            UPD_STEP: word_d = word_q + WORD_W'(1);
            default:  word_d = word_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign vaddr_o = {word_q, 1'b0};

    logic unused_base_lsb;
    assign unused_base_lsb = base_addr_i[0];
endmodule

// File: rtl/vid_addr_gen_chk.sv
module vid_addr_gen_chk #(
    parameter int ADDR_W = 24,
    parameter int SKIP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_i,
    input logic              line_end_i,
    input logic              frame_start_i,
    input logic [ADDR_W-1:0] base_addr_i,
    input logic [SKIP_W-1:0] line_skip_i,
    input logic [ADDR_W-1:0] vaddr_o
);
    logic              started;
    logic              line_prev;
    logic              rise;
    logic [ADDR_W-1:0] skip_bytes;
    logic [ADDR_W-1:0] base_even;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started   <= 1'b0;
            line_prev <= 1'b0;
        end else begin
            if (frame_start_i) started <= 1'b1;
            line_prev <= line_end_i;
        end
    end

    assign rise       = line_end_i && !line_prev;
    assign skip_bytes = ADDR_W'({line_skip_i, 1'b0});
    assign base_even  = {base_addr_i[ADDR_W-1:1], 1'b0};

    a_r9_bit0_low: assert property (@(posedge clk) disable iff (!rst_n)
        vaddr_o[0] == 1'b0);

    a_r1_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && !frame_start_i) |=> $stable(vaddr_o));

    a_r2_frame_load: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> vaddr_o == $past(base_even));

    a_r4_line_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (started && rise && !frame_start_i)
        |=> vaddr_o == $past(vaddr_o) + $past(skip_bytes));

    a_r3_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
        (started && fetch_i && !rise && !frame_start_i)
        |=> vaddr_o == $past(vaddr_o) + ADDR_W'(2));
endmodule

bind vid_addr_gen vid_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .SKIP_W (SKIP_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_i       (fetch_i),
    .line_end_i    (line_end_i),
    .frame_start_i (frame_start_i),
    .base_addr_i   (base_addr_i),
    .line_skip_i   (line_skip_i),
    .vaddr_o       (vaddr_o)
);

// File: tb/vid_addr_gen_tb_top.sv
`timescale 1ns/1ps
module vid_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 1'b0;
    logic        line_end_i = 1'b0;
    logic        frame_start_i = 1'b0;
    logic [23:0] base_addr_i = '0;
    logic [7:0]  line_skip_i = '0;
    logic [23:0] vaddr_o;

    int total = 0;
    int fails = 0;

    logic [23:0] m_addr = '0;
    logic        m_run = 1'b0;
    logic        m_prev = 1'b0;

    always #2 clk = ~clk;

    vid_addr_gen dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_i       (fetch_i),
        .line_end_i    (line_end_i),
        .frame_start_i (frame_start_i),
        .base_addr_i   (base_addr_i),
        .line_skip_i   (line_skip_i),
        .vaddr_o       (vaddr_o)
    );

    task automatic chk(input string tag, input logic [23:0] exp);
        total++;
        if (vaddr_o !== exp) begin
            fails++;
            $display("FAIL %s: vaddr_o=%06h expected %06h", tag, vaddr_o, exp);
        end
    endtask

    // Drive one cycle, update the arithmetic model, sample after the edge.
    task automatic cyc(input logic f, input logic l, input logic s,
                       input logic [23:0] b);
        @(negedge clk);
        fetch_i = f; line_end_i = l; frame_start_i = s; base_addr_i = b;
        if (s) begin
            m_addr = b & 24'hFFFFFE;
            m_run  = 1'b1;
        end else if (m_run) begin
            if (l && !m_prev) m_addr = m_addr + {15'd0, line_skip_i, 1'b0};
            else if (f)       m_addr = m_addr + 24'd2;
        end
        m_prev = l;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R1 reset value", 24'h000000);
        @(negedge clk); rst_n = 1'b1;
        // R1: halted before first frame start
        line_skip_i = 8'h33;
        cyc(1, 0, 0, 24'h0); cyc(0, 1, 0, 24'h0); cyc(1, 1, 0, 24'h0);
        cyc(0, 0, 0, 24'h0);
        chk("R1 ignored before frame start", 24'h000000);
        // R2 / R9: load with bit 0 cleared
        cyc(0, 0, 1, 24'h123457);
        chk("R2 R9 frame load", 24'h123456);
        // R3: fetch steps
        cyc(1, 0, 0, 24'h0); chk("R3 fetch step", m_addr);
        cyc(1, 0, 0, 24'h0); chk("R3 fetch step 2", 24'h12345A);
        // R2 priority over fetch and line rise
        cyc(1, 1, 1, 24'h00ABCD);
        chk("R2 priority", 24'h00ABCC);
        cyc(0, 0, 0, 24'h0);
        // R5: majority carry example
        line_skip_i = 8'h0F;
        cyc(0, 0, 1, 24'h0000A8);
        cyc(0, 1, 0, 24'h0);
        chk("R5 majority carry", 24'h0000C6);
        // R6: held line end adds once, later fetches step
        cyc(0, 0, 0, 24'h0);
        line_skip_i = 8'h20;
        cyc(1, 1, 0, 24'h0); chk("R7 fetch with rise", 24'h000106);
        cyc(1, 1, 0, 24'h0); chk("R6 held line step", 24'h000108);
        cyc(1, 1, 0, 24'h0); chk("R6 held line step 2", 24'h00010A);
        cyc(0, 1, 0, 24'h0); chk("R6 held line no re-add", 24'h00010A);
        cyc(0, 0, 0, 24'h0);
        // R10: zero skip
        line_skip_i = 8'h00;
        cyc(0, 1, 0, 24'h0); chk("R10 zero skip", 24'h00010A);
        cyc(0, 0, 0, 24'h0);
        // R8: wrap
        line_skip_i = 8'h10;
        cyc(0, 0, 1, 24'hFFFFF0);
        cyc(0, 1, 0, 24'h0); chk("R8 wrap", 24'h000010);
        cyc(0, 0, 0, 24'h0);
        // R4: sweep every skip over several bases
        foreach (sweep_base[i]) begin
            cyc(0, 0, 1, sweep_base[i]);
            for (int ofs = 0; ofs < 256; ofs++) begin
                line_skip_i = 8'(ofs);
                for (int k = 0; k <= ofs % 4; k++) cyc(1, 0, 0, 24'h0);
                cyc(0, 1, 0, 24'h0);
                chk("R4 sweep line skip", m_addr);
            end
            cyc(0, 0, 0, 24'h0);
        end
        finish_run();
    end

    logic [23:0] sweep_base [3] = '{24'h000000, 24'h3FFF01, 24'hFFF800};
endmodule